// File: doc/BRIEF.md
# Two-Phase Piezo Drive Waveform Generator

This block produces the two square-wave phases for one ultrasonic piezo motor. Both phases share one frequency, which is set by a period value counted in system clocks. One phase is a copy of the other delayed by a quarter period. A direction input picks which of the two phases leads.

A burst starts when a nonzero pulse count is loaded. The block then emits exactly that many output periods and forces both phases low. A zero count stops the motor at once. A synchronous active-low power-down input also holds both phases low and discards any burst in progress.

The block has an optional clock doubler. It is enabled only when this motor's enable bit and the companion motor's enable bit are both set. With the doubler on, the internal timebase advances two counts per clock. A slower system clock then produces the same output frequencies as without the doubler.

Top module: `piezo_phase_gen`

## Requirements
- R1: With the doubler off, the leading phase repeats every P clocks, where P is `period_i`, a value of 4 to 255. Its rising edges fall at burst-relative counts 0, P, 2P and so on.
- R2: The high time of each phase is floor(P/2) counts when `width_i` is 0, and `width_i` counts otherwise. `width_i` is assumed to be at most floor(P/2).
- R3: The lagging phase is the leading phase delayed by floor(P/4) counts. Both phases carry the same number of pulses, and they never rise in the same cycle.
- R4: When `dir_i` is 0, `phase_a_o` leads and `phase_b_o` lags. When `dir_i` is 1, `phase_b_o` leads and `phase_a_o` lags.
- R5: A burst loaded with N = 1 to 2047 lasts exactly N periods. After that, `active_o`, `phase_a_o` and `phase_b_o` are all 0.
- R6: A load with `pulses_i` = 0 clears `active_o` and both phases in the next cycle, even in mid-burst. When the block is idle, such a load has no effect.
- R7: While `pd_n` is 0, both phases and `active_o` are 0 from the next cycle on, and loads are ignored. When `pd_n` returns to 1, the block stays idle until a new load arrives.
- R8: A nonzero load during a burst takes effect at the next period boundary. A new burst then starts from count 0 with the new settings. A load that arrives in the boundary cycle itself takes effect at that boundary.
- R9: The doubler is active only if `dbl_self_i` and `dbl_peer_i` are both 1 when the load is sampled. When active, the timebase advances 2 counts per clock. Period, width and shift all stay in counts.
- R10: After reset, and whenever the block is idle, both phases and `active_o` are 0. Period, width, direction and doubler settings are captured when the load is accepted.
- R11: One cycle after a nonzero load is accepted by an idle block, `active_o` is 1, the leading phase is 1 and the lagging phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Synchronous active-low power-down |
| period_i | input | 8 | Period length in timebase counts |
| width_i | input | 8 | High time in counts; 0 selects half period |
| dir_i | input | 1 | Direction; 0 means phase A leads |
| pulses_i | input | 11 | Number of periods in the burst; 0 stops the motor |
| load_i | input | 1 | Load strobe for all settings |
| dbl_self_i | input | 1 | Doubler enable bit of this motor |
| dbl_peer_i | input | 1 | Doubler enable bit of the companion motor |
| phase_a_o | output | 1 | Drive phase A |
| phase_b_o | output | 1 | Drive phase B |
| active_o | output | 1 | A burst is running |

## Verification
Two events can land in the same cycle: a new nonzero load, and the period boundary at which the running count would be decremented. The bench provokes this by placing a load exactly in the last clock of a period. It also places a second load several clocks before a boundary, so that the load must wait. In both cases, every cycle from the boundary onward is compared against a fresh burst computed arithmetically from the new settings. The expected waveform starts at count 0 in the cycle right after the boundary, and the old count must not be decremented.

// File: rtl/piezo_phase_pkg.sv
package piezo_phase_pkg;

    parameter int unsigned PIEZO_PW = 8;   // period / width / position bits
    parameter int unsigned PIEZO_CW = 11;  // burst pulse count bits

    typedef logic [PIEZO_PW-1:0] piezo_cnt_t;
    typedef logic [PIEZO_CW-1:0] piezo_pulses_t;

    typedef struct packed {
        piezo_cnt_t period;
        piezo_cnt_t width;
        logic       dir;
        logic       dbl;
    } piezo_cfg_t;

endpackage

// File: rtl/piezo_timebase.sv
module piezo_timebase
    import piezo_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clear_i,
    input  piezo_cfg_t cfg_i,
    output piezo_cnt_t pos_o,
    output logic       wrap_o
);

    localparam int unsigned SW = PIEZO_PW + 1;

    typedef struct packed {
        piezo_cnt_t pos;
    } tb_state_t;

    tb_state_t       s_q, s_d;
    piezo_cnt_t      step;
    logic [SW-1:0]   sum_wide;
    logic            wrap;

    always_comb begin
        step     = cfg_i.dbl ? piezo_cnt_t'(2) : piezo_cnt_t'(1);
        sum_wide = {1'b0, s_q.pos} + {1'b0, step};
        wrap     = run_i && (sum_wide >= {1'b0, cfg_i.period});
        s_d      = s_q;
        if (clear_i || !run_i) begin
            s_d.pos = '0;
        end else if (wrap) begin
            s_d.pos = s_q.pos + step - cfg_i.period;
        end else begin
            s_d.pos = s_q.pos + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_o  = s_q.pos;
    assign wrap_o = wrap;

endmodule

// File: rtl/piezo_burst_ctrl.sv
module piezo_burst_ctrl
    import piezo_phase_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_n,
    input  logic          load_i,
    input  piezo_pulses_t pulses_i,
    input  piezo_cfg_t    cfg_in_i,
    input  logic          wrap_i,
    output logic          run_o,
    output piezo_cfg_t    cfg_o,
    output logic          clear_o
);

    localparam piezo_pulses_t LAST = piezo_pulses_t'(1);

    typedef struct packed {
        logic          run;
        piezo_pulses_t rem;
        piezo_cfg_t    cfg;
        logic          pend;
        piezo_pulses_t pend_cnt;
        piezo_cfg_t    pend_cfg;
    } ctrl_state_t;

    ctrl_state_t s_q, s_d;
    logic        restart;

    always_comb begin
        s_d     = s_q;
        restart = 1'b0;
        if (!pd_n) begin
            s_d.run  = 1'b0;
            s_d.pend = 1'b0;
            s_d.rem  = '0;
        end else if (load_i && (pulses_i == '0)) begin
            s_d.run  = 1'b0;
            s_d.pend = 1'b0;
            s_d.rem  = '0;
        end else if (load_i && (!s_q.run || wrap_i)) begin
            s_d.run  = 1'b1;
            s_d.rem  = pulses_i;
            s_d.cfg  = cfg_in_i;
            s_d.pend = 1'b0;
            restart  = 1'b1;
        end else begin
            if (load_i) begin
                s_d.pend     = 1'b1;
                s_d.pend_cnt = pulses_i;
                s_d.pend_cfg = cfg_in_i;
            end
            if (s_q.run && wrap_i) begin
                if (s_q.pend) begin
                    s_d.rem  = s_q.pend_cnt;
                    s_d.cfg  = s_q.pend_cfg;
                    s_d.pend = 1'b0;
                    restart  = 1'b1;
                end else begin
                    s_d.rem = s_q.rem - LAST;
                    if (s_q.rem == LAST) begin
                        s_d.run = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o   = s_q.run;
    assign cfg_o   = s_q.cfg;
    assign clear_o = restart || !s_d.run;

endmodule

// File: rtl/piezo_phase_decode.sv
module piezo_phase_decode
    import piezo_phase_pkg::*;
(
    input  logic       run_i,
    input  piezo_cfg_t cfg_i,
    input  piezo_cnt_t pos_i,
    output logic       phase_a_o,
    output logic       phase_b_o
);

    piezo_cnt_t high_len;
    piezo_cnt_t shift;
    piezo_cnt_t lag_pos;
    logic       lead;
    logic       lag;

    always_comb begin
        high_len = (cfg_i.width == '0) ? (cfg_i.period >> 1) : cfg_i.width;
        shift    = cfg_i.period >> 2;
        if (pos_i >= shift) begin
            lag_pos = pos_i - shift;
        end else begin
            lag_pos = pos_i + cfg_i.period - shift;
        end
        lead = run_i && (pos_i < high_len);
        lag  = run_i && (lag_pos < high_len);
        phase_a_o = cfg_i.dir ? lag  : lead;
        phase_b_o = cfg_i.dir ? lead : lag;
    end

endmodule

// File: rtl/piezo_phase_gen.sv
module piezo_phase_gen
    import piezo_phase_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_n,
    input  logic [PIEZO_PW-1:0] period_i,
    input  logic [PIEZO_PW-1:0] width_i,
    input  logic                dir_i,
    input  logic [PIEZO_CW-1:0] pulses_i,
    input  logic                load_i,
    input  logic                dbl_self_i,
    input  logic                dbl_peer_i,
    output logic                phase_a_o,
    output logic                phase_b_o,
    output logic                active_o
);

    piezo_cfg_t cfg_in;
    piezo_cfg_t cfg_run;
    piezo_cnt_t pos;
    logic       run;
    logic       wrap;
    logic       clear;

    always_comb begin
        cfg_in.period = period_i;
        cfg_in.width  = width_i;
        cfg_in.dir    = dir_i;
        cfg_in.dbl    = dbl_self_i & dbl_peer_i;
    end

    piezo_burst_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .load_i   (load_i),
        .pulses_i (pulses_i),
        .cfg_in_i (cfg_in),
        .wrap_i   (wrap),
        .run_o    (run),
        .cfg_o    (cfg_run),
        .clear_o  (clear)
    );

    piezo_timebase tbase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clear_i (clear),
        .cfg_i   (cfg_run),
        .pos_o   (pos),
        .wrap_o  (wrap)
    );

    piezo_phase_decode dec_i (
        .run_i     (run),
        .cfg_i     (cfg_run),
        .pos_i     (pos),
        .phase_a_o (phase_a_o),
        .phase_b_o (phase_b_o)
    );

    assign active_o = run;

endmodule

// File: rtl/piezo_phase_gen_chk.sv
module piezo_phase_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pd_n,
    input logic        dir_i,
    input logic [10:0] pulses_i,
    input logic        load_i,
    input logic        phase_a_o,
    input logic        phase_b_o,
    input logic        active_o
);

    // R7
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!active_o && !phase_a_o && !phase_b_o));

    // R6
    zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && load_i && pulses_i == 11'd0) |=> (!active_o && !phase_a_o && !phase_b_o));

    // R11
    start_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && load_i && pulses_i != 11'd0 && !active_o)
        |=> (active_o && ($past(dir_i) ? (phase_b_o && !phase_a_o) : (phase_a_o && !phase_b_o))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !(pd_n && load_i && pulses_i != 11'd0)) |=> !active_o);

    // R8
    reload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && pd_n && load_i && pulses_i != 11'd0) |=> active_o);

    // R3
    no_joint_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(phase_a_o) && $rose(phase_b_o)));

endmodule

bind piezo_phase_gen piezo_phase_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .dir_i     (dir_i),
    .pulses_i  (pulses_i),
    .load_i    (load_i),
    .phase_a_o (phase_a_o),
    .phase_b_o (phase_b_o),
    .active_o  (active_o)
);

// File: tb/piezo_phase_gen_tb_top.sv
module piezo_phase_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic [7:0]  period_i = 8'd0;
    logic [7:0]  width_i = 8'd0;
    logic        dir_i = 1'b0;
    logic [10:0] pulses_i = 11'd0;
    logic        load_i = 1'b0;
    logic        dbl_self_i = 1'b0;
    logic        dbl_peer_i = 1'b0;
    logic        phase_a_o, phase_b_o, active_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    piezo_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .period_i(period_i),
        .width_i(width_i), .dir_i(dir_i), .pulses_i(pulses_i), .load_i(load_i),
        .dbl_self_i(dbl_self_i), .dbl_peer_i(dbl_peer_i),
        .phase_a_o(phase_a_o), .phase_b_o(phase_b_o), .active_o(active_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs at burst-relative cycle t, from the requirement arithmetic
    function automatic void model(input int t, input int p, input int w, input int s,
                                  input int n, input bit dir,
                                  output bit ea, output bit eb, output bit ev);
        int h, q, c;
        bit lead, lag;
        h  = (w == 0) ? p / 2 : w;
        q  = p / 4;
        c  = s * t;
        ev = (c < n * p);
        lead = ev && ((c % p) < h);
        lag  = ev && (c >= q) && (((c - q) % p) < h);
        ea = dir ? lag : lead;
        eb = dir ? lead : lag;
    endfunction

    task automatic drive(input int p, input int w, input bit dir, input bit da,
                         input bit db, input int n);
        period_i   = 8'(p);
        width_i    = 8'(w);
        dir_i      = dir;
        dbl_self_i = da;
        dbl_peer_i = db;
        pulses_i   = 11'(n);
        load_i     = 1'b1;
    endtask

    task automatic launch(input int p, input int w, input bit dir, input bit da,
                          input bit db, input int n);
        @(negedge clk);
        drive(p, w, dir, da, db, n);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic follow(input int p, input int w, input bit dir, input int s, input int n,
                          input int t0, input int cnt, input string tag);
        for (int t = t0; t < t0 + cnt; t++) begin
            bit ea, eb, ev;
            string tg;
            model(t, p, w, s, n, dir, ea, eb, ev);
            tg = (t == 0) ? "R11" : (!ev ? "R5" : tag);
            chk(phase_a_o, ea, tg, "phase_a");
            chk(phase_b_o, eb, tg, "phase_b");
            chk(active_o, ev, tg, "active");
            @(negedge clk);
        end
    endtask

    task automatic all_low(input string tag);
        chk(phase_a_o, 1'b0, tag, "phase_a");
        chk(phase_b_o, 1'b0, tag, "phase_b");
        chk(active_o, 1'b0, tag, "active");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        all_low("R10");
        rst_n = 1'b1;
        @(negedge clk);
        all_low("R10");

        // zero load while idle: no effect (R6)
        drive(10, 0, 0, 0, 0, 0);
        @(negedge clk);
        load_i = 1'b0;
        repeat (3) begin all_low("R6"); @(negedge clk); end

        // sweep: periods, widths, directions, doubler variants, counts
        for (int p = 8; p <= 20; p++) begin
            for (int wi = 0; wi < 4; wi++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    for (int d = 0; d < 3; d++) begin
                        for (int ni = 0; ni < 2; ni++) begin
                            int w, n, s, len;
                            string tg;
                            w = (wi == 0) ? 0 : (wi == 1) ? 1 : (wi == 2) ? p / 4 : p / 2;
                            n = (ni == 0) ? 1 : 3;
                            s = (d == 2) ? 2 : 1;
                            tg = (d == 2) ? "R9 doubled" : (d == 1) ? "R9 one-enable"
                               : (dir == 1) ? "R4" : "R1/R2/R3";
                            len = (n * p + s - 1) / s;
                            launch(p, w, bit'(dir), d >= 1, d == 2, n);
                            follow(p, w, bit'(dir), s, n, 0, len + 2, tg);
                        end
                    end
                end
            end
        end

        // operating-range periods
        launch(111, 0, 0, 0, 0, 2);
        follow(111, 0, 0, 1, 2, 0, 224, "R1");
        launch(143, 40, 1, 1, 1, 2);
        follow(143, 40, 1, 2, 2, 0, 145, "R9");

        // mid-burst zero load stops at once (R6)
        launch(10, 0, 0, 0, 0, 5);
        follow(10, 0, 0, 1, 5, 0, 13, "R1");
        drive(10, 0, 0, 0, 0, 0);
        @(negedge clk);
        load_i = 1'b0;
        repeat (20) begin all_low("R6"); @(negedge clk); end

        // pending restart: load mid-period waits for the boundary (R8)
        launch(10, 0, 0, 0, 0, 3);
        follow(10, 0, 0, 1, 3, 0, 13, "R1");
        drive(10, 3, 1, 0, 0, 2);
        @(negedge clk);
        load_i = 1'b0;
        follow(10, 0, 0, 1, 3, 14, 6, "R8 old");
        follow(10, 3, 1, 1, 2, 0, 22, "R8 new");

        // coincident load on the boundary cycle (R8)
        launch(10, 0, 0, 0, 0, 3);
        follow(10, 0, 0, 1, 3, 0, 9, "R1");
        drive(12, 0, 1, 1, 1, 2);
        @(negedge clk);
        load_i = 1'b0;
        follow(12, 0, 1, 2, 2, 0, 14, "R8 same-cycle");

        // power-down mid-burst, loads ignored while down (R7)
        launch(12, 0, 1, 0, 0, 4);
        follow(12, 0, 1, 1, 4, 0, 7, "R4");
        pd_n = 1'b0;
        @(negedge clk);
        all_low("R7");
        drive(12, 0, 0, 0, 0, 2);
        @(negedge clk);
        load_i = 1'b0;
        all_low("R7");
        @(negedge clk);
        pd_n = 1'b1;
        repeat (5) begin @(negedge clk); all_low("R7"); end

        // longest burst (R5)
        launch(8, 0, 0, 0, 0, 2047);
        follow(8, 0, 0, 1, 2047, 0, 2047 * 8 + 3, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule